// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns single-word requests from a synchronous valid/ready port into strobe sequences for an asynchronous 1M x 16 fast-page-mode DRAM. The memory has 1024 rows of 1024 columns. The row number and the column number share a 10-bit address bus. The row is taken in when RAS falls, and the column is taken in when a CAS strobe falls. There is one CAS strobe for each byte lane.

After an access, the controller leaves the row open. A later request to the same row is served by a CAS-only cycle. A request to a different row first closes the page, waits out the precharge time and then opens the new row. If no request arrives for a set number of cycles, the page is closed. A refresh requester outside the block asks for a CAS-before-RAS refresh through a request/acknowledge pair. Refresh takes priority over pending traffic. All timing values are parameters counted in controller clock cycles.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the DRAM strobes RAS, both CAS, WE and OE are all high, `req_ready` is high and `rsp_valid` is low.
- R2: A request address is split as row = `req_addr[19:10]` and column = `req_addr[9:0]`. When RAS falls for an access, the row is on `dram_addr`. The column is on `dram_addr` one cycle before a CAS strobe falls, and it is unchanged when that strobe falls.
- R3: A request whose row equals the open row is served without a new falling edge on RAS.
- R4: Before RAS falls to open a row, RAS has been high for at least `T_PRE` cycles.
- R5: In a write, WE is low in the cycle before CAS falls and stays low while CAS is low. `dram_ucas_n` falls only if `req_be[1]` is set, for bits 15:8. `dram_lcas_n` falls only if `req_be[0]` is set, for bits 7:0. The data is driven on `dram_dq_out`.
- R6: A read holds OE low and pulls both CAS strobes low for exactly `T_CAS` cycles. The data on `dram_dq_in` is sampled in the last of those cycles and appears on `rsp_rdata` with a one-cycle `rsp_valid` pulse.
- R7: A refresh request closes any open page and waits the precharge time. Both CAS strobes then fall while RAS is high, and RAS is held low for exactly `T_RAS` cycles. `ref_ack` is high for one cycle, in the last of those cycles. The next access must reopen its row.
- R8: When `ref_req` and `req_valid` are both present, the refresh is carried out first. `req_ready` is low while `ref_req` is high and in every cycle in which the sequencer is busy with an access or a refresh.
- R9: An open page with no request for `T_IDLE` consecutive cycles is closed, which raises RAS. It stays open before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper 10 bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| ref_req | input | 1 | Refresh requested, held until acknowledged |
| ref_ack | output | 1 | Refresh complete pulse |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the memory |
| dram_dq_in | input | 16 | Data returned by the memory |

## Verification
A refresh request and a host request can arrive in the same cycle while a page is open. The bench raises `ref_req` and `req_valid` on the same clock low phase, for a read to the row that is already open. The outcome is judged at the pins. The bench checks that `req_ready` stays low, that a CAS-before-RAS cycle is seen before the read, and that RAS falls twice: once for the refresh and once to reopen the row. The read must still return the stored word.

// File: rtl/fpm_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes: one sequencer instance uses these encodings; no other block decodes them.
package fpm_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OPEN, S_PRE, S_ACT, S_COL, S_CAS, S_CBR, S_RFSH
    } fpm_state_e;

    typedef enum logic [1:0] {
        GO_IDLE, GO_ACT, GO_REF
    } fpm_tgt_e;
endpackage

// File: rtl/fpm_cnt.sv
// Loadable down-counter that stops at zero and flags it.
// Assumes: load has priority; the caller loads N-1 to mark N cycles.
module fpm_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] q;

    // count down toward zero, reloading on request
    always_ff @(posedge clk) begin
        if (!rst_n)           q <= '0;
        else if (load)        q <= load_val;
        else if (q != '0)     q <= q - 1'b1;
    end

    assign zero = (q == '0);
endmodule

// File: rtl/fpm_row_track.sv
// Holds the number of the row currently open in the DRAM and compares it with incoming rows.
// Assumes: open_en and close_en are never high together; a row is opened only while none is open.
module fpm_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] row_d,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit,
    output logic             open_vld
);
    logic [ROW_W-1:0] open_row;

    // record the row when it is opened, forget it when the page closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (open_en) begin
            open_vld <= 1'b1;
            open_row <= row_d;
        end else if (close_en) begin
            open_vld <= 1'b0;
        end
    end

    assign hit = open_vld && (cmp_row == open_row);

    // R4: a new row is opened only after the previous page was closed
    a_r4_open_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |-> !open_vld);
endmodule

// File: rtl/fpm_ctrl.sv
// Fast-page-mode DRAM controller: sequences RAS/CAS/WE/OE for single-word requests,
// keeps the last row open for CAS-only hits and runs CAS-before-RAS refresh on demand.
// Assumes: all T_* parameters are at least 1; the DRAM is 16 bits wide with two byte strobes.
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int T_PRE  = 2,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RAS  = 3,
    parameter int T_IDLE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [1:0]               req_be,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic                     ref_req,
    output logic                     ref_ack,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_ucas_n,
    output logic                     dram_lcas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [DATA_W-1:0]        dram_dq_out,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int AB_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int M1     = (T_PRE > T_RCD) ? T_PRE : T_RCD;
    localparam int M2     = (T_CAS > T_RAS) ? T_CAS : T_RAS;
    localparam int PH_MAX = (M1 > M2) ? M1 : M2;
    localparam int PH_W   = $clog2(PH_MAX) + 1;
    localparam int ID_W   = $clog2(T_IDLE) + 1;

    fpm_state_e st, st_n;
    fpm_tgt_e   tgt, tgt_n;

    logic              ph_load, ph_zero, idle_zero, accept;
    logic [PH_W-1:0]   ph_val;
    logic              row_open, row_close, hit, open_vld;
    logic [ROW_W-1:0]  lat_row, row_d;
    logic [COL_W-1:0]  lat_col;
    logic              lat_wr;
    logic [1:0]        lat_be;
    logic [DATA_W-1:0] lat_wdata;
    logic              read_done;

    wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
    wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];

    fpm_cnt #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero));

    fpm_cnt #(.W(ID_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .load(st != S_OPEN),
        .load_val(ID_W'(T_IDLE - 1)), .zero(idle_zero));

    assign row_d = (st == S_IDLE) ? req_row : lat_row;

    fpm_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .open_en(row_open), .close_en(row_close),
        .row_d(row_d), .cmp_row(req_row), .hit(hit), .open_vld(open_vld));

    assign req_ready = ((st == S_IDLE) || (st == S_OPEN)) && !ref_req;
    assign ref_ack   = (st == S_RFSH) && ph_zero;
    assign read_done = (st == S_CAS) && ph_zero && !lat_wr;

    // next-state, phase-counter loads and row tracker updates
    always_comb begin
        st_n      = st;
        tgt_n     = tgt;
        ph_load   = 1'b0;
        ph_val    = '0;
        accept    = 1'b0;
        row_open  = 1'b0;
        row_close = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (ref_req) begin
                    st_n = S_CBR;
                end else if (req_valid) begin
                    accept = 1'b1; row_open = 1'b1;
                    st_n = S_ACT; ph_load = 1'b1; ph_val = PH_W'(T_RCD - 1);
                end
            end
            S_OPEN: begin
                if (ref_req || (req_valid && !hit) || (!req_valid && idle_zero)) begin
                    st_n = S_PRE; ph_load = 1'b1; ph_val = PH_W'(T_PRE - 1);
                    row_close = 1'b1;
                    tgt_n = ref_req ? GO_REF : (req_valid ? GO_ACT : GO_IDLE);
                    accept = !ref_req && req_valid;
                end else if (req_valid) begin
                    accept = 1'b1; st_n = S_COL;
                end
            end
            S_PRE: begin
                if (ph_zero) begin
                    unique case (tgt)
                        GO_ACT: begin
                            st_n = S_ACT; row_open = 1'b1;
                            ph_load = 1'b1; ph_val = PH_W'(T_RCD - 1);
                        end
                        GO_REF:  st_n = S_CBR;
                        default: st_n = S_IDLE;
                    endcase
                end
            end
            S_ACT:  if (ph_zero) st_n = S_COL;
            S_COL:  begin st_n = S_CAS; ph_load = 1'b1; ph_val = PH_W'(T_CAS - 1); end
            S_CAS:  if (ph_zero) st_n = S_OPEN;
            S_CBR:  begin st_n = S_RFSH; ph_load = 1'b1; ph_val = PH_W'(T_RAS - 1); end
            S_RFSH: begin
                if (ph_zero) begin
                    st_n = S_PRE; tgt_n = GO_IDLE;
                    ph_load = 1'b1; ph_val = PH_W'(T_PRE - 1);
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            tgt <= GO_IDLE;
        end else begin
            st  <= st_n;
            tgt <= tgt_n;
        end
    end

    // capture the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_row <= '0; lat_col <= '0; lat_wr <= 1'b0;
            lat_be  <= '0; lat_wdata <= '0;
        end else if (accept) begin
            lat_row <= req_row; lat_col <= req_col; lat_wr <= req_write;
            lat_be  <= req_be;  lat_wdata <= req_wdata;
        end
    end

    // sample read data at the end of the column strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= read_done;
            if (read_done) rsp_rdata <= dram_dq_in;
        end
    end

    // decode DRAM pins from the registered state
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_ucas_n = 1'b1;
        dram_lcas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_addr   = AB_W'(lat_col);
        unique case (st)
            S_PRE:  dram_addr = AB_W'(lat_row);
            S_ACT:  begin dram_ras_n = 1'b0; dram_addr = AB_W'(lat_row); end
            S_OPEN: dram_ras_n = 1'b0;
            S_COL:  begin dram_ras_n = 1'b0; dram_we_n = !lat_wr; end
            S_CAS: begin
                dram_ras_n  = 1'b0;
                dram_we_n   = !lat_wr;
                dram_oe_n   = lat_wr;
                dram_ucas_n = lat_wr ? !lat_be[1] : 1'b0;
                dram_lcas_n = lat_wr ? !lat_be[0] : 1'b0;
            end
            S_CBR:  begin dram_ucas_n = 1'b0; dram_lcas_n = 1'b0; end
            S_RFSH: begin dram_ras_n = 1'b0; dram_ucas_n = 1'b0; dram_lcas_n = 1'b0; end
            default: ;
        endcase
    end

    assign dram_dq_out = lat_wdata;

    // R3: a same-row request keeps the row strobe low
    a_r3_hit_keeps_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OPEN && !ref_req && req_valid && hit) |=> !dram_ras_n);

    // R2, R5: address and write enable are settled before a column strobe falls
    a_r5_setup_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && $fell(dram_lcas_n && dram_ucas_n)) |-> ($stable(dram_we_n) && $stable(dram_addr)));

    // R6: read response is a single-cycle pulse
    a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: acknowledge only while the refresh strobes are all low
    a_r7_ack_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (!dram_ras_n && !dram_lcas_n && !dram_ucas_n));

    // R8: a refresh request closes an open page at once
    a_r8_ref_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && st == S_OPEN) |=> dram_ras_n);

    // R9: an expired idle window closes the page
    a_r9_idle_close: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OPEN && idle_zero && !req_valid && !ref_req) |=> dram_ras_n);

    // R3: the open page always has a tracked row
    a_r3_open_tracked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_OPEN) |-> open_vld);
endmodule

// File: tb/tb_fpm_ctrl.sv
// Self-checking bench: behavioural page-mode DRAM model plus a table-driven access sequence
// and directed tests for reset, idle close, refresh and refresh/request collision.
module tb_fpm_ctrl;
    localparam int T_PRE = 2, T_RCD = 2, T_CAS = 2, T_RAS = 3, T_IDLE = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ref_req = 1'b0;
    logic        req_ready, rsp_valid, ref_ack;
    logic [15:0] rsp_rdata, dram_dq_out, dram_dq_in;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fpm_ctrl #(.T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_IDLE(T_IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
        .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- DRAM model, sampled on the falling clock edge ----------------
    logic [15:0] mem [0:255];
    logic [9:0]  mrow = '0, mcol = '0, p_addr = '0;
    logic        p_ras = 1'b1, p_cas = 1'b0, p_we = 1'b1, in_ref = 1'b0, cas_now;
    int          ras_hi = 100, cas_lo = 0, ref_lo = 0, ras_falls = 0, cbr_seen = 0;

    assign dram_dq_in = dram_oe_n ? 16'h0000 : mem[{mrow[2:0], mcol[4:0]}];

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
            p_ras = 1'b1; p_cas = 1'b0; p_we = 1'b1; in_ref = 1'b0; ras_hi = 100;
        end else begin
            cas_now = !(dram_lcas_n && dram_ucas_n);
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                if (cas_now) begin cbr_seen++; in_ref = 1'b1; ref_lo = 0; end
                else begin
                    mrow = dram_addr;
                    chk(ras_hi >= T_PRE, "R4 precharge", ras_hi, T_PRE);
                end
            end
            if (!dram_ras_n && !in_ref && !p_cas && cas_now) begin
                mcol = dram_addr;
                chk(dram_addr == p_addr, "R2 column setup", dram_addr, p_addr);
                chk(dram_we_n == p_we, "R5 WE setup", dram_we_n, p_we);
                cas_lo = 0;
                if (!dram_we_n) begin
                    if (!dram_lcas_n) mem[{mrow[2:0], mcol[4:0]}][7:0]  = dram_dq_out[7:0];
                    if (!dram_ucas_n) mem[{mrow[2:0], mcol[4:0]}][15:8] = dram_dq_out[15:8];
                end
            end
            if (cas_now && !in_ref) cas_lo++;
            if (p_cas && !cas_now && !in_ref) chk(cas_lo == T_CAS, "R6 CAS width", cas_lo, T_CAS);
            if (!dram_ras_n && in_ref) ref_lo++;
            if (!p_ras && dram_ras_n) begin
                if (in_ref) chk(ref_lo == T_RAS, "R7 refresh RAS width", ref_lo, T_RAS);
                in_ref = 1'b0;
            end
            ras_hi = dram_ras_n ? ras_hi + 1 : 0;
            p_ras = dram_ras_n; p_cas = cas_now; p_addr = dram_addr; p_we = dram_we_n;
        end
    end

    // ---------------- request driver ----------------
    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd);
        int n;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ready, "R8 busy not ready", req_ready, 0);
        rd = '0;
        if (!wr) begin
            n = 0;
            while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
            chk(rsp_valid, "R6 response", rsp_valid, 1);
            rd = rsp_rdata;
        end
    endtask

    // {write, addr[19:0], wdata, be, expected read, expected new RAS falls}
    localparam logic [55:0] VEC [0:8] = '{
        {1'b1, 20'h00403, 16'hA1B2, 2'b11, 16'h0000, 1'b1},
        {1'b1, 20'h00404, 16'hC3D4, 2'b11, 16'h0000, 1'b0},
        {1'b0, 20'h00403, 16'h0000, 2'b11, 16'hA1B2, 1'b0},
        {1'b1, 20'h00403, 16'h55EE, 2'b01, 16'h0000, 1'b0},
        {1'b0, 20'h00403, 16'h0000, 2'b11, 16'hA1EE, 1'b0},
        {1'b1, 20'h00803, 16'h7788, 2'b10, 16'h0000, 1'b1},
        {1'b0, 20'h00803, 16'h0000, 2'b11, 16'h7700, 1'b0},
        {1'b0, 20'h00404, 16'h0000, 2'b11, 16'hC3D4, 1'b1},
        {1'b0, 20'h00403, 16'h0000, 2'b11, 16'hA1EE, 1'b0}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int r0, c0, n;
        repeat (5) @(negedge clk);
        // R1: strobes and handshake while reset is held
        chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n,
            "R1 strobes in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n,
            "R1 strobes after reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'h1f);
        chk(req_ready && !rsp_valid, "R1 handshake", {req_ready, rsp_valid}, 2'b10);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 9; i++) begin
            r0 = ras_falls;
            do_req(VEC[i][55], VEC[i][54:35], VEC[i][34:19], VEC[i][18:17], rd);
            while (!req_ready) @(negedge clk);
            chk(ras_falls - r0 == int'(VEC[i][0]), VEC[i][0] ? "R4 row change" : "R3 page hit",
                ras_falls - r0, VEC[i][0]);
            if (!VEC[i][55]) chk(rd == VEC[i][16:1], "R5/R6 read data", rd, VEC[i][16:1]);
        end

        // R9: page stays open briefly, then closes after the idle window
        repeat (2) @(negedge clk);
        chk(!dram_ras_n, "R9 page still open", dram_ras_n, 0);
        repeat (T_IDLE + T_PRE + 2) @(negedge clk);
        chk(dram_ras_n, "R9 idle close", dram_ras_n, 1);
        r0 = ras_falls;
        do_req(1'b0, 20'h00403, 16'h0, 2'b11, rd);
        chk(ras_falls - r0 == 1 && rd == 16'hA1EE, "R9 reopen after idle", {ras_falls - r0, rd}, {32'd1, 16'hA1EE});

        // R7: refresh while a page is open
        @(negedge clk);
        r0 = ras_falls; c0 = cbr_seen;
        ref_req = 1'b1;
        #1 chk(!req_ready, "R8 ready low during refresh request", req_ready, 0);
        n = 0;
        while (!ref_ack && n < 100) begin @(negedge clk); n++; end
        chk(ref_ack, "R7 acknowledge", ref_ack, 1);
        chk(cbr_seen - c0 == 1, "R7 CAS-before-RAS seen", cbr_seen - c0, 1);
        @(posedge clk); #1 ref_req = 1'b0;
        @(negedge clk);
        chk(!ref_ack, "R7 acknowledge is one cycle", ref_ack, 0);
        r0 = ras_falls;
        do_req(1'b0, 20'h00404, 16'h0, 2'b11, rd);
        chk(ras_falls - r0 == 1 && rd == 16'hC3D4, "R7 row reopened after refresh",
            {ras_falls - r0, rd}, {32'd1, 16'hC3D4});

        // R8: refresh and same-row request in the same cycle
        @(negedge clk);
        r0 = ras_falls; c0 = cbr_seen;
        ref_req = 1'b1;
        #1 chk(!req_ready, "R8 ready low on collision", req_ready, 0);
        fork
            begin
                while (!ref_ack) @(negedge clk);
                @(posedge clk); #1 ref_req = 1'b0;
            end
            do_req(1'b0, 20'h00404, 16'h0, 2'b11, rd);
        join
        chk(cbr_seen - c0 == 1, "R8 refresh served", cbr_seen - c0, 1);
        chk(ras_falls - r0 == 2, "R8 refresh before request", ras_falls - r0, 2);
        chk(rd == 16'hC3D4, "R8 data after collision", rd, 16'hC3D4);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule